// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Aggregator

This block gathers event pulses from nine audio DMA channels into one sticky status word and raises a single interrupt line to the processor. Each channel reports three kinds of event: period complete, underrun and error. Every event is a single-cycle pulse. Each channel's three events occupy a group of three adjacent bits, and the group for channel `c` starts at bit `3*c`. That makes a 27-bit status word.

Software uses a plain address, write-data and write-enable port. Through it, software sets which status bits may interrupt, reads the status either raw or masked by those enables, clears bits by writing ones, and can inject status bits itself for test. The interrupt line is a level: it is high while any enabled status bit is set. It therefore produces a fresh rising edge for an edge-triggered receiver once software has cleared everything and a new enabled event arrives.

Top module: `irqAgg`

## Requirements
- R1: After reset, the enable word and the raw status word are zero, the interrupt output is low, and every register reads zero.
- R2: A pulse on channel `c` sets raw status bit `3*c+k`, where `k` is 0 for period complete, 1 for underrun and 2 for error. The bit is visible after the clock edge that samples the pulse.
- R3: A raw status bit that has been set stays set on later cycles until software clears it.
- R4: A write to offset 0x0C clears every raw status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged. Offset 0x0C reads zero.
- R5: A write to offset 0x10 sets every raw status bit whose write-data bit is 1, exactly as a hardware event would. Offset 0x10 reads zero.
- R6: Offset 0x00 holds the enable word and reads back what was written. Offset 0x04 reads the raw status ANDed with the enable word. Offset 0x08 reads the raw status.
- R7: The interrupt output is high exactly when some status bit is both set and enabled. A status bit that is set while disabled drives no interrupt, and a status bit that was cleared before its enable was written does not fire.
- R8: When a set (hardware pulse or force write) and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: Bits 27 to 31 of every register read as zero, and writes to them have no effect.
- R10: Once all status is cleared the interrupt output is low, and a later enabled event drives it from low to high.
- R11: Reads of any offset other than 0x00, 0x04 and 0x08 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| perDone | input | 9 | Period-complete pulses, one bit per channel |
| underrun | input | 9 | Underrun pulses, one bit per channel |
| errEvt | input | 9 | Error pulses, one bit per channel |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The bench sweeps all 27 pairs of channel and event kind, one at a time. For each pair it checks that the pulse lands on exactly bit `3*c+k`, which catches any mix-up of channels or kinds. It then writes a clear with every other bit set, to show that zeros in a clear write leave the bit alone. Next it clears the bit and enables it, to show that a cleared event stays quiet when enabled. Finally it forces the bit, to compare the masked view with the raw view and to check the interrupt level.

Separate patterns cover the remaining cases. A pulse and a clear on the same bit in the same cycle checks that the set wins. A clear-everything step followed by a new pulse checks for a fresh low-to-high edge. All-ones writes check that the upper bits stay zero, and reads of the write-only and unmapped offsets check that they return zero.

// File: rtl/irqAggPkg.sv
`timescale 1ns/1ps
package irqAggPkg;

  // number of status bits per channel and their positions inside a group
  localparam int EVT_W     = 3;
  localparam int KIND_PER  = 0;
  localparam int KIND_UNDR = 1;
  localparam int KIND_ERR  = 2;

  // register byte offsets
  localparam int OFF_EN     = 'h00;
  localparam int OFF_MASKED = 'h04;
  localparam int OFF_RAW    = 'h08;
  localparam int OFF_CLR    = 'h0C;
  localparam int OFF_FORCE  = 'h10;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_EN     = 2'd1,
    RD_MASKED = 2'd2,
    RD_RAW    = 2'd3
  } rdSelT;

  typedef struct packed {
    logic  enWr;
    logic  clrWr;
    logic  forceWr;
    rdSelT rdSel;
  } regStrobeT;

endpackage

// File: rtl/irqAggCtrl.sv
`timescale 1ns/1ps
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobeT         strobe
);

  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(OFF_FORCE);

  always_comb begin
    strobe.enWr    = regWe && (regAddr == A_EN);
    strobe.clrWr   = regWe && (regAddr == A_CLR);
    strobe.forceWr = regWe && (regAddr == A_FORCE);
    if (regAddr == A_EN)          strobe.rdSel = RD_EN;
    else if (regAddr == A_MASKED) strobe.rdSel = RD_MASKED;
    else if (regAddr == A_RAW)    strobe.rdSel = RD_RAW;
    else                          strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqAggDatapath.sv
`timescale 1ns/1ps
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int DATA_W = 32,
  localparam int STAT_W = NUM_CH * EVT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] perDone,
  input  logic [NUM_CH-1:0] underrun,
  input  logic [NUM_CH-1:0] errEvt,
  input  regStrobeT         strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [STAT_W-1:0] rawStat,
  output logic [STAT_W-1:0] enMask,
  output logic              irqOut
);

  logic [STAT_W-1:0] hwSet;
  logic [STAT_W-1:0] wrStat;
  logic [STAT_W-1:0] clrVec;
  logic [STAT_W-1:0] forceVec;
  logic [STAT_W-1:0] rawQ;
  logic [STAT_W-1:0] enQ;
  logic [STAT_W-1:0] maskedStat;
  logic              unusedWdata;

  assign wrStat      = regWdata[STAT_W-1:0];
  assign unusedWdata = ^regWdata[DATA_W-1:STAT_W];

  // pack each channel's pulses into its three-bit group
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pack
    assign hwSet[ch*EVT_W + KIND_PER]  = perDone[ch];
    assign hwSet[ch*EVT_W + KIND_UNDR] = underrun[ch];
    assign hwSet[ch*EVT_W + KIND_ERR]  = errEvt[ch];
  end

  assign clrVec   = strobe.clrWr   ? wrStat : '0;
  assign forceVec = strobe.forceWr ? wrStat : '0;

  // set terms are ORed after the clear so a colliding event survives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ <= '0;
      enQ  <= '0;
    end else begin
      rawQ <= (rawQ & ~clrVec) | hwSet | forceVec;
      if (strobe.enWr) enQ <= wrStat;
    end
  end

  assign maskedStat = rawQ & enQ;
  assign irqOut     = |maskedStat;
  assign rawStat    = rawQ;
  assign enMask     = enQ;

  always_comb begin
    case (strobe.rdSel)
      RD_EN:     regRdata = DATA_W'(enQ);
      RD_MASKED: regRdata = DATA_W'(maskedStat);
      RD_RAW:    regRdata = DATA_W'(rawQ);
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/irqAgg.sv
`timescale 1ns/1ps
module irqAgg
  import irqAggPkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STAT_W = NUM_CH * EVT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] perDone,
  input  logic [NUM_CH-1:0] underrun,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  regStrobeT         strobe;
  logic [STAT_W-1:0] rawStat;
  logic [STAT_W-1:0] enMask;

  irqAggCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  irqAggDatapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .perDone  (perDone),
    .underrun (underrun),
    .errEvt   (errEvt),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .rawStat  (rawStat),
    .enMask   (enMask),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/irqAggChecker.sv
`timescale 1ns/1ps
module irqAggChecker
  import irqAggPkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int STAT_W = NUM_CH * EVT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] perDone,
  input logic [NUM_CH-1:0] underrun,
  input logic [NUM_CH-1:0] errEvt,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic [STAT_W-1:0] rawStat,
  input logic [STAT_W-1:0] enMask,
  input logic              irqOut
);

  logic [STAT_W-1:0] evVec;
  logic [STAT_W-1:0] wdLow;
  logic              clrHit;
  logic              forceHit;
  logic              unusedHi;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      evVec[c*EVT_W + KIND_PER]  = perDone[c];
      evVec[c*EVT_W + KIND_UNDR] = underrun[c];
      evVec[c*EVT_W + KIND_ERR]  = errEvt[c];
    end
  end

  assign wdLow    = regWdata[STAT_W-1:0];
  assign unusedHi = ^regWdata[DATA_W-1:STAT_W];
  assign clrHit   = regWe && (regAddr == ADDR_W'(OFF_CLR));
  assign forceHit = regWe && (regAddr == ADDR_W'(OFF_FORCE));

  // R2 and R8: every pulsed bit is set on the next cycle, even under a clear
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evVec != '0) |=> ((rawStat & $past(evVec)) == $past(evVec)));

  // R3: without a clear, no set bit falls
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!clrHit) |=> ((rawStat & $past(rawStat)) == $past(rawStat)));

  // R4: a clear with no concurrent set empties the written bits
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && evVec == '0) |=> ((rawStat & $past(wdLow)) == '0));

  // R5: a force write sets the written bits
  assert_force_R5: assert property (@(posedge clk) disable iff (!rstN)
    forceHit |=> ((rawStat & $past(wdLow)) == $past(wdLow)));

  // R6: the masked view never shows a disabled bit
  assert_masked_view_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_MASKED)) |-> ((regRdata[STAT_W-1:0] & ~enMask) == '0));

  // R7: with nothing enabled the line stays low
  assert_no_irq_when_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |-> !irqOut);

  // R9: upper read bits are always zero
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:STAT_W] == '0);

endmodule

bind irqAgg irqAggChecker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .perDone  (perDone),
  .underrun (underrun),
  .errEvt   (errEvt),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .rawStat  (rawStat),
  .enMask   (enMask),
  .irqOut   (irqOut)
);

// File: tb/tb_irqAgg.sv
`timescale 1ns/1ps
module tb_irqAgg;

  localparam int NUM_CH = 9;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STAT_W = NUM_CH * 3;
  localparam logic [31:0] FULL = (32'd1 << STAT_W) - 32'd1;

  localparam logic [7:0] A_EN  = 8'h00;
  localparam logic [7:0] A_MSK = 8'h04;
  localparam logic [7:0] A_RAW = 8'h08;
  localparam logic [7:0] A_CLR = 8'h0C;
  localparam logic [7:0] A_FRC = 8'h10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] perDone = '0;
  logic [NUM_CH-1:0] underrun = '0;
  logic [NUM_CH-1:0] errEvt = '0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              irqOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  irqAgg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .perDone(perDone), .underrun(underrun),
    .errEvt(errEvt), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; ends at the next negedge
  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic setPulse(input int ch, input int k, input logic v);
    case (k)
      0: perDone[ch] = v;
      1: underrun[ch] = v;
      default: errEvt[ch] = v;
    endcase
  endtask

  task automatic pulseEvt(input int ch, input int k);
    setPulse(ch, k, 1'b1);
    @(posedge clk);
    @(negedge clk);
    setPulse(ch, k, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] bitv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    readReg(A_EN, rd);  check("R1 en", rd, 32'd0);
    readReg(A_RAW, rd); check("R1 raw", rd, 32'd0);
    readReg(A_MSK, rd); check("R1 masked", rd, 32'd0);
    @(negedge clk);

    // sweep over every channel and event kind
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 0; k < 3; k++) begin
        bitv = 32'd1 << (3 * ch + k);
        pulseEvt(ch, k);
        readReg(A_RAW, rd);  check($sformatf("R2 raw ch%0d k%0d", ch, k), rd, bitv);
        check("R7 disabled irq", {31'd0, irqOut}, 32'd0);
        @(negedge clk);
        writeReg(A_CLR, FULL & ~bitv);
        readReg(A_RAW, rd);  check("R4 zero bits keep", rd, bitv);
        @(negedge clk);
        writeReg(A_CLR, bitv);
        readReg(A_RAW, rd);  check("R4 one bit clears", rd, 32'd0);
        @(negedge clk);
        writeReg(A_EN, bitv);
        check("R7 no stale fire", {31'd0, irqOut}, 32'd0);
        writeReg(A_FRC, bitv);
        check("R5 force irq", {31'd0, irqOut}, 32'd1);
        readReg(A_MSK, rd);  check("R6 masked", rd, bitv);
        readReg(A_EN, rd);   check("R6 enable readback", rd, bitv);
        @(negedge clk);
        writeReg(A_CLR, bitv);
        check("R7 irq drops", {31'd0, irqOut}, 32'd0);
        writeReg(A_EN, 32'd0);
      end
    end

    // R3 sticky over several idle cycles
    pulseEvt(3, 1);
    repeat (5) @(negedge clk);
    readReg(A_RAW, rd); check("R3 sticky", rd, 32'd1 << 10);
    @(negedge clk);
    writeReg(A_CLR, FULL);

    // R8 set and clear on the same bit in the same cycle
    pulseEvt(5, 2);
    regAddr = A_CLR; regWdata = 32'd1 << 17; regWe = 1'b1;
    errEvt[5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; errEvt[5] = 1'b0;
    readReg(A_RAW, rd); check("R8 set wins", rd, 32'd1 << 17);
    @(negedge clk);
    writeReg(A_CLR, FULL);

    // R10 fresh rising edge after full clear
    writeReg(A_EN, FULL);
    check("R10 low before", {31'd0, irqOut}, 32'd0);
    pulseEvt(8, 2);
    check("R10 rises", {31'd0, irqOut}, 32'd1);
    pulseEvt(2, 0);
    writeReg(A_CLR, FULL);
    check("R10 low after clear", {31'd0, irqOut}, 32'd0);
    pulseEvt(0, 0);
    check("R10 rises again", {31'd0, irqOut}, 32'd1);
    writeReg(A_CLR, FULL);

    // R9 upper bits
    writeReg(A_EN, 32'hFFFF_FFFF);
    readReg(A_EN, rd);  check("R9 enable upper", rd, FULL);
    @(negedge clk);
    writeReg(A_FRC, 32'hFFFF_FFFF);
    readReg(A_RAW, rd); check("R9 raw upper", rd, FULL);
    readReg(A_MSK, rd); check("R9 masked upper", rd, FULL);

    // R11 and R4/R5 read zero offsets
    readReg(A_CLR, rd); check("R4 clear reads zero", rd, 32'd0);
    readReg(A_FRC, rd); check("R5 force reads zero", rd, 32'd0);
    readReg(8'h14, rd); check("R11 unmapped", rd, 32'd0);
    readReg(8'h02, rd); check("R11 misaligned", rd, 32'd0);
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule